// File: doc/BRIEF.md
# Serial Flash Maintenance Command Sequencer

This block is a host-side serial master that performs two maintenance operations on a serial configuration flash: writing the status register (typically to change its block-protection bits) and erasing one sector. A single accepted request covers the whole operation. The block sends the write-enable frame that the flash requires, then the command frame, then polls the status register until the flash finishes its self-timed internal cycle.

The request side is a valid/ready input. `req_ready` is high only while the sequencer is idle. A request transfers on a cycle where `req_valid` and `req_ready` are both high. While an operation runs, `req_ready` stays low and `req_valid` is ignored, so a requester may hold a pending request until `req_ready` returns. Completion is a plain one-cycle `op_done` pulse, and `op_timeout` qualifies it.

On the serial side the clock idles low. Outgoing data changes only on its falling edge, and incoming data is sampled on its rising edge. Each half period of the serial clock lasts `HALF_DIV` system clocks. The flash's busy cycle can take milliseconds, so a polling watchdog with a limit of `TIMEOUT_CYCLES` system clocks ends an operation whose busy bit never clears.

Top module: `flash_maint_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `req_ready` is 1 and `op_done` is 0.
- R2: A request is taken only while `req_ready` is high. `req_ready` falls in the cycle after acceptance and stays low until the operation completes. A `req_valid` asserted meanwhile changes neither the frames sent nor the result.
- R3: With `req_op`=0 (status write), the first frame is the 8-bit opcode 0x06. The second frame is exactly 16 bits: opcode 0x01 followed by `req_data`. Chip select rises right after the last data bit.
- R4: With `req_op`=1 (sector erase), the 0x06 frame is followed by one 32-bit frame: opcode 0xD8, then `req_addr[23:0]`, sent most significant bit first.
- R5: After the command frame, the block repeats 16-bit status-read frames. Each frame is opcode 0x05 followed by 8 clocks with the data line held at 0, and the status byte is read MSB first. Polling stops at the first frame whose status bit 0 (write in progress) is 0. The other status bits have no effect.
- R6: Between frames, chip select stays high for at least 2*`HALF_DIV` system clocks. While chip select is high, `spi_sclk` is 0.
- R7: If bit 0 is still 1 at the end of a poll and `TIMEOUT_CYCLES` system clocks have passed since polling began, the operation ends with `op_timeout`=1. The operation then spans at least `TIMEOUT_CYCLES` cycles after acceptance.
- R8: `op_done` is a single-cycle pulse. `op_timeout` is 1 only together with `op_done`, and it is 0 on a normal completion.
- R9: `spi_mosi` does not change while `spi_sclk` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 1 | 0 = status write, 1 = sector erase |
| req_data | input | 8 | Status byte to write |
| req_addr | input | 24 | Any address inside the sector to erase |
| op_done | output | 1 | One-cycle completion pulse |
| op_timeout | output | 1 | With `op_done`: busy bit never cleared |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is the timeout path. It requires a flash that reports busy on every poll for longer than the watchdog limit, which a real device never does. The bench uses a behavioural flash whose busy count the test sets: a count far larger than the polls that fit in the limit forces the timeout, and a count of two gives a short polling run. The model reports status bytes with the upper bits set, so that only bit 0 can end the polling. A test also holds a different request on the input while an operation is in flight.

// File: rtl/fms_pkg.sv
package fms_pkg;
  localparam int FRAME_W = 32;
  localparam int CNT_W   = 6;
  localparam int WIP_BIT = 0;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_ERASE = 8'hD8;

  typedef enum logic {
    OP_STATUS_WR = 1'b0,
    OP_ERASE     = 1'b1
  } maint_op_e;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_LOW, ENG_HIGH, ENG_TAIL, ENG_GAP
  } eng_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE, SEQ_WREN, SEQ_CMD, SEQ_POLL
  } seq_state_e;
endpackage

// File: rtl/fms_spi_engine.sv
module fms_spi_engine
  import fms_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [CNT_W-1:0]   tx_bits,
  input  logic               rx_en,
  output logic               busy,
  output logic               done,
  output logic [7:0]         rx_byte,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int DIV_W = $clog2(2 * HALF_DIV + 1);
  localparam logic [DIV_W-1:0] HALF_END = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0] GAP_END  = DIV_W'(2 * HALF_DIV - 1);

  eng_state_e         state;
  logic [DIV_W-1:0]   div;
  logic [CNT_W-1:0]   bits_left;
  logic [FRAME_W-1:0] sh;

  assign busy = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      div       <= '0;
      bits_left <= '0;
      sh        <= '0;
      rx_byte   <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
      mosi      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start) begin
            cs_n      <= 1'b0;
            mosi      <= tx_word[FRAME_W-1];
            sh        <= tx_word << 1;
            bits_left <= tx_bits + (rx_en ? CNT_W'(8) : CNT_W'(0));
            div       <= '0;
            state     <= ENG_LOW;
          end
        end
        ENG_LOW: begin
          if (div == HALF_END) begin
            div     <= '0;
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
            state   <= ENG_HIGH;
          end else begin
            div <= div + 1'b1;
          end
        end
        ENG_HIGH: begin
          if (div == HALF_END) begin
            div       <= '0;
            sclk      <= 1'b0;
            bits_left <= bits_left - 1'b1;
            if (bits_left == CNT_W'(1)) begin
              state <= ENG_TAIL;
            end else begin
              mosi  <= sh[FRAME_W-1];
              sh    <= sh << 1;
              state <= ENG_LOW;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        ENG_TAIL: begin
          if (div == HALF_END) begin
            div   <= '0;
            cs_n  <= 1'b1;
            state <= ENG_GAP;
          end else begin
            div <= div + 1'b1;
          end
        end
        ENG_GAP: begin
          if (div == GAP_END) begin
            div   <= '0;
            done  <= 1'b1;
            state <= ENG_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R6: serial clock parked low whenever the flash is deselected
  assert_sclk_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R9: data line holds through the high phase of the serial clock
  assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R6: a new frame is only launched from idle, after the gap
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !cs_n);
endmodule

// File: rtl/fms_watchdog.sv
module fms_watchdog #(
  parameter int LIMIT = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  // R7: the window restarts whenever polling is not active
  assert_wd_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !expired);
endmodule

// File: rtl/fms_ctrl.sv
module fms_ctrl
  import fms_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_op,
  input  logic [7:0]         req_data,
  input  logic [23:0]        req_addr,
  input  logic               eng_done,
  input  logic [7:0]         eng_rx,
  input  logic               wd_expired,
  output logic               wd_run,
  output logic               eng_start,
  output logic [FRAME_W-1:0] eng_tx,
  output logic [CNT_W-1:0]   eng_bits,
  output logic               eng_rx_en,
  output logic               op_done,
  output logic               op_timeout
);
  seq_state_e  state;
  maint_op_e   lat_op;
  logic [7:0]  lat_data;
  logic [23:0] lat_addr;

  assign req_ready = (state == SEQ_IDLE);
  assign wd_run    = (state == SEQ_POLL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      lat_op     <= OP_STATUS_WR;
      lat_data   <= '0;
      lat_addr   <= '0;
      eng_start  <= 1'b0;
      eng_tx     <= '0;
      eng_bits   <= '0;
      eng_rx_en  <= 1'b0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
    end else begin
      eng_start  <= 1'b0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (req_valid) begin
            lat_op    <= maint_op_e'(req_op);
            lat_data  <= req_data;
            lat_addr  <= req_addr;
            eng_start <= 1'b1;
            eng_tx    <= {OPC_WREN, 24'h0};
            eng_bits  <= CNT_W'(8);
            eng_rx_en <= 1'b0;
            state     <= SEQ_WREN;
          end
        end
        SEQ_WREN: begin
          if (eng_done) begin
            eng_start <= 1'b1;
            eng_rx_en <= 1'b0;
            if (lat_op == OP_ERASE) begin
              eng_tx   <= {OPC_ERASE, lat_addr};
              eng_bits <= CNT_W'(32);
            end else begin
              eng_tx   <= {OPC_WRSR, lat_data, 16'h0};
              eng_bits <= CNT_W'(16);
            end
            state <= SEQ_CMD;
          end
        end
        SEQ_CMD: begin
          if (eng_done) begin
            eng_start <= 1'b1;
            eng_tx    <= {OPC_RDSR, 24'h0};
            eng_bits  <= CNT_W'(8);
            eng_rx_en <= 1'b1;
            state     <= SEQ_POLL;
          end
        end
        SEQ_POLL: begin
          if (eng_done) begin
            if (!eng_rx[WIP_BIT]) begin
              op_done <= 1'b1;
              state   <= SEQ_IDLE;
            end else if (wd_expired) begin
              op_done    <= 1'b1;
              op_timeout <= 1'b1;
              state      <= SEQ_IDLE;
            end else begin
              eng_start <= 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R2: acceptance closes the request channel on the next cycle
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: completion pulse lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R8: timeout only qualifies a completion
  assert_timeout_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_timeout |-> op_done);

  // R5: a normal completion follows a status byte with the busy bit clear
  assert_clean_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_timeout) |-> !eng_rx[WIP_BIT]);

  // R7: a timeout is reported only once the polling window ran out
  assert_timeout_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_timeout |-> $past(wd_expired));
endmodule

// File: rtl/flash_maint_seq.sv
module flash_maint_seq
  import fms_pkg::*;
#(
  parameter int HALF_DIV       = 4,
  parameter int TIMEOUT_CYCLES = 750000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_op,
  input  logic [7:0]  req_data,
  input  logic [23:0] req_addr,
  output logic        op_done,
  output logic        op_timeout,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic               eng_start, eng_done, eng_busy, eng_rx_en;
  logic [FRAME_W-1:0] eng_tx;
  logic [CNT_W-1:0]   eng_bits;
  logic [7:0]         eng_rx;
  logic               wd_run, wd_expired;

  fms_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_data   (req_data),
    .req_addr   (req_addr),
    .eng_done   (eng_done),
    .eng_rx     (eng_rx),
    .wd_expired (wd_expired),
    .wd_run     (wd_run),
    .eng_start  (eng_start),
    .eng_tx     (eng_tx),
    .eng_bits   (eng_bits),
    .eng_rx_en  (eng_rx_en),
    .op_done    (op_done),
    .op_timeout (op_timeout)
  );

  fms_spi_engine #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .tx_word (eng_tx),
    .tx_bits (eng_bits),
    .rx_en   (eng_rx_en),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  fms_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wd_run),
    .expired (wd_expired)
  );

  // R2: the sequencer never starts a frame while the engine is still busy
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);
endmodule

// File: tb/flash_maint_seq_test.sv
module flash_maint_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int TMO        = 1200;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [7:0]  req_data = '0;
  logic [23:0] req_addr = '0;
  logic        op_done, op_timeout;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_maint_seq #(.HALF_DIV(HALF), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .req_addr(req_addr),
    .op_done(op_done), .op_timeout(op_timeout), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // behavioural flash
  logic        log_en = 1'b0;
  int          busy_left = 0;
  int          bitcnt = 0;
  logic [63:0] cap = '0;
  logic [7:0]  op_byte = '0;
  logic [7:0]  status_now = '0;
  logic [63:0] f_data [0:31];
  int          f_bits [0:31];
  int          f_count = 0;

  always @(negedge spi_cs_n) begin
    if (log_en) begin
      bitcnt     = 0;
      cap        = '0;
      op_byte    = '0;
      status_now = {7'b1010_000, (busy_left > 0)};
    end
  end

  always @(posedge spi_sclk) begin
    if (log_en && !spi_cs_n) begin
      cap    = {cap[62:0], spi_mosi};
      bitcnt = bitcnt + 1;
      if (bitcnt == 8) op_byte = cap[7:0];
    end
  end

  always @(negedge spi_sclk) begin
    if (log_en && !spi_cs_n && op_byte == 8'h05 && bitcnt >= 8 && bitcnt < 16)
      spi_miso = status_now[15 - bitcnt];
  end

  always @(posedge spi_cs_n) begin
    if (log_en) begin
      if (f_count < 32) begin
        f_data[f_count] = cap;
        f_bits[f_count] = bitcnt;
      end
      f_count = f_count + 1;
      if (op_byte == 8'h05 && bitcnt == 16 && busy_left > 0) busy_left = busy_left - 1;
      spi_miso = 1'b0;
    end
  end

  // line monitors
  int   gap_cnt = 0;
  int   min_gap = 1000000;
  int   sclk_bad = 0;
  int   mosi_bad = 0;
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;
  logic prev_mosi = 1'b0;

  always @(posedge clk) begin
    if (log_en) begin
      if (prev_cs && !spi_cs_n && gap_cnt < min_gap) min_gap = gap_cnt;
      if (spi_cs_n) gap_cnt = gap_cnt + 1; else gap_cnt = 0;
      if (spi_cs_n && spi_sclk) sclk_bad = sclk_bad + 1;
      if (prev_sclk && spi_sclk && (spi_mosi !== prev_mosi)) mosi_bad = mosi_bad + 1;
      prev_cs   = spi_cs_n;
      prev_sclk = spi_sclk;
      prev_mosi = spi_mosi;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [7:0] d, input logic [23:0] a,
                        input int busy_n, input bit stray,
                        output int cycles, output logic to, output int width,
                        output int ready_seen);
    busy_left  = busy_n;
    f_count    = 0;
    ready_seen = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d; req_addr = a;
    @(negedge clk);
    req_valid = stray;
    req_op    = ~op;
    req_data  = 8'hFF;
    req_addr  = 24'hFFFFFF;
    cycles = 1;
    while (!op_done && cycles < 30000) begin
      if (cycles == 100) req_valid = 1'b0;
      if (req_ready) ready_seen++;
      @(negedge clk);
      cycles++;
    end
    req_valid = 1'b0;
    to = op_timeout;
    width = 0;
    while (op_done && width < 10) begin
      width++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "cs_n after reset", 64'(spi_cs_n), 64'd1);
    chk("R1", "sclk after reset", 64'(spi_sclk), 64'd0);
    chk("R1", "ready after reset", 64'(req_ready), 64'd1);
    chk("R1", "done after reset", 64'(op_done), 64'd0);
  endtask

  task automatic t_status_write;
    int c, w, rs; logic to;
    run_op(1'b0, 8'h3C, 24'h0, 2, 1'b0, c, to, w, rs);
    chk("R5", "status-write frame count", 64'(f_count), 64'd5);
    chk("R3", "enable frame bits", 64'(f_bits[0]), 64'd8);
    chk("R3", "enable frame data", f_data[0], 64'h06);
    chk("R3", "write frame bits", 64'(f_bits[1]), 64'd16);
    chk("R3", "write frame data", f_data[1], 64'h013C);
    for (int i = 2; i < 5; i++) begin
      chk("R5", "poll frame bits", 64'(f_bits[i]), 64'd16);
      chk("R5", "poll frame data", f_data[i], 64'h0500);
    end
    chk("R8", "no timeout on normal finish", 64'(to), 64'd0);
    chk("R8", "done pulse width", 64'(w), 64'd1);
  endtask

  task automatic t_erase;
    int c, w, rs; logic to;
    run_op(1'b1, 8'h00, 24'h12A5F0, 0, 1'b0, c, to, w, rs);
    chk("R4", "erase frame count", 64'(f_count), 64'd3);
    chk("R4", "enable frame data", f_data[0], 64'h06);
    chk("R4", "erase frame bits", 64'(f_bits[1]), 64'd32);
    chk("R4", "erase frame data", f_data[1], 64'hD812A5F0);
    chk("R5", "single poll data", f_data[2], 64'h0500);
    chk("R8", "no timeout on erase", 64'(to), 64'd0);
    chk("R8", "erase done width", 64'(w), 64'd1);
  endtask

  task automatic t_ignore;
    int c, w, rs; logic to;
    run_op(1'b0, 8'h5A, 24'h0, 0, 1'b1, c, to, w, rs);
    chk("R2", "ready while busy", 64'(rs), 64'd0);
    chk("R2", "frames with stray request", 64'(f_count), 64'd3);
    chk("R2", "write frame unchanged", f_data[1], 64'h015A);
    chk("R2", "result unchanged", 64'(to), 64'd0);
    repeat (20) @(negedge clk);
    chk("R2", "no extra frame after stray", 64'(f_count), 64'd3);
  endtask

  task automatic t_timeout;
    int c, w, rs; logic to;
    run_op(1'b1, 8'h00, 24'h000100, 100000, 1'b0, c, to, w, rs);
    chk("R7", "timeout flag", 64'(to), 64'd1);
    chk("R7", "span reaches limit", 64'(c >= TMO), 64'd1);
    chk("R7", "span bounded", 64'(c <= TMO + 400), 64'd1);
    chk("R7", "several polls", 64'(f_count >= 4), 64'd1);
    chk("R8", "timeout done width", 64'(w), 64'd1);
    chk("R7", "idle after timeout", 64'(req_ready), 64'd1);
  endtask

  task automatic t_lines;
    chk("R6", "minimum deselect gap", 64'(min_gap >= 2*HALF), 64'd1);
    chk("R6", "sclk high while deselected", 64'(sclk_bad), 64'd0);
    chk("R9", "mosi moved in high phase", 64'(mosi_bad), 64'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n  = 1'b1;
    log_en = 1'b1;
    t_reset();
    t_status_write();
    t_erase();
    t_ignore();
    t_timeout();
    t_status_write();
    t_lines();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule